// File: doc/BRIEF.md
# Six-Channel DMA Request Arbiter

This block sits between six DMA channel engines and the shared transfer engine. Each channel raises a request line. The arbiter picks one requester and drives a one-hot grant with a valid flag. It holds that grant until the transfer engine pulses a completion strobe. A 16-bit configuration word sets the order used to pick a channel. It offers ascending fixed order, a fixed order that promotes channels 2 and 3 above channel 1, and a rotating order.

The same word can also throttle the grant rate. When every channel reports that it runs in cycle-steal bus mode, a pacing code limits grants to one per 16 or one per 64 bus-clock enables. This leaves the external bus mostly free for other masters. If any channel is in another bus mode, the pacing code has no effect. Codes that are not defined are kept in the register and read back as written, but they behave like the zero code of their field.

Top module: `dma_req_arbiter`

## Requirements
- R1: The readback shows bit 13:12 (pacing code) and bit 9:8 (order code) exactly as last written. Every other bit reads 0 whatever was written, so writing 0xFFFF reads back 0x3300.
- R2: `grant_o` has exactly one bit set while `grant_vld_o` is 1, and is all zero while `grant_vld_o` is 0. Bit n of `grant_o` means channel n.
- R3: With order code 00 the lowest-numbered requesting channel wins (0 highest, 5 lowest). A grant only ever goes to a channel that was requesting.
- R4: With order code 01 the ranking is 0, 2, 3, 1, 4, 5, from highest to lowest.
- R5: With order code 11 the search starts at the channel after the last one granted and wraps from 5 to 0. After reset the search starts at channel 0. The last-granted pointer advances on every grant, whatever the order code.
- R6: The undefined codes (order 10, pacing 01) are stored and read back unchanged. Order 10 behaves as order 00, and pacing 01 behaves as pacing 00.
- R7: A grant stays unchanged until `xfer_done_i` is sampled high. It is cleared on that same edge, and the earliest next grant comes on the following edge.
- R8: With pacing code 10 and all six `steal_mode_i` bits set, a new grant needs 16 edges with `busclk_en_i` high since the previous grant. With `busclk_en_i` held high and an immediate done, grants are 17 cycles apart. With `busclk_en_i` low, no new grant issues.
- R9: With pacing code 11 and all channels in cycle-steal mode, the gap is 64 bus-clock enables (65 cycles with the enable held high).
- R10: If any `steal_mode_i` bit is 0, pacing is off. Back-to-back grants are then 2 cycles apart with an immediate done.
- R11: Reset clears the register to 0x0000 and removes every grant. The first grant after reset is not held back by pacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 6 | Transfer request, one bit per channel |
| steal_mode_i | input | 6 | Channel n runs in cycle-steal bus mode |
| busclk_en_i | input | 1 | One-cycle pulse per external bus clock |
| cfg_wr_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration readback |
| xfer_done_i | input | 1 | Granted transfer has completed |
| grant_o | output | 6 | One-hot grant |
| grant_vld_o | output | 1 | A grant is active |

## Verification
Each fault has its own signature at the ports:
- A corrupted rotation pointer shows up on the very next grant as a channel out of sequence.
- A wrong order decode shows up on the first contended grant.
- A pacing counter that restarts too late or saturates wrongly moves the gap between grants away from 17 or 65 cycles. The bench counts that gap edge by edge.
- A hold or release fault shows up one cycle after the done strobe, as a grant that lingers or changes early.

// File: rtl/dmarb_pkg.sv
// Shared constants and types for the DMA request arbiter.
// Assumes a 16-bit configuration word with two live 2-bit fields.
package dmarb_pkg;
    localparam int CFG_W     = 16;
    localparam int ORDER_LSB = 8;
    localparam int PACE_LSB  = 12;
    localparam int GAP_SHORT = 16;
    localparam int GAP_LONG  = 64;
    localparam logic [CFG_W-1:0] CFG_LIVE_MASK = 16'h3300;

    typedef enum logic [1:0] {
        ORD_ASCEND,
        ORD_SKIP,
        ORD_ROTATE
    } order_e;

    typedef enum logic [1:0] {
        PACE_NONE,
        PACE_SHORT,
        PACE_LONG
    } pace_e;
endpackage

// File: rtl/dmarb_cfg_reg.sv
// Configuration word: keeps the order and pacing codes, returns the
// readback with the reserved bits forced to 0, and decodes the codes into
// the behaviour actually used. Undefined codes decode to the zero code.
module dmarb_cfg_reg
    import dmarb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] rdata_o,
    output order_e           order_o,
    output pace_e            pace_o
);
    logic [1:0] order_q;
    logic [1:0] pace_q;
    logic       unused_wbits;

    assign unused_wbits = ^{wdata_i[15:14], wdata_i[11:10], wdata_i[7:0]};

    // Capture the two live fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= 2'b00;
            pace_q  <= 2'b00;
        end else if (wr_en_i) begin
            order_q <= wdata_i[ORDER_LSB +: 2];
            pace_q  <= wdata_i[PACE_LSB +: 2];
        end
    end

    // Build the readback with the reserved bits at zero.
    always_comb begin
        rdata_o = '0;
        rdata_o[ORDER_LSB +: 2] = order_q;
        rdata_o[PACE_LSB +: 2]  = pace_q;
    end

    // Map the stored codes to the behaviour in force.
    always_comb begin
        case (order_q)
            2'b01:   order_o = ORD_SKIP;
            2'b11:   order_o = ORD_ROTATE;
            default: order_o = ORD_ASCEND;
        endcase
        case (pace_q)
            2'b10:   pace_o = PACE_SHORT;
            2'b11:   pace_o = PACE_LONG;
            default: pace_o = PACE_NONE;
        endcase
    end
endmodule

// File: rtl/dmarb_pacer.sv
// Pacing gate: counts bus-clock enables since the last grant, saturating at
// the long gap, and allows a grant once the selected gap has elapsed. The gate
// is open whenever pacing is off or any channel is not in cycle-steal mode.
// The count starts saturated so the first grant after reset is never held back.
module dmarb_pacer
    import dmarb_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_en_i,
    input  pace_e          pace_i,
    input  logic [NCH-1:0] steal_i,
    input  logic           restart_i,
    output logic           open_o
);
    localparam int CNT_W = $clog2(GAP_LONG + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(GAP_LONG);
    localparam logic [CNT_W-1:0] CNT_SHRT = CNT_W'(GAP_SHORT);

    logic [CNT_W-1:0] cnt_q;
    logic             active;
    logic [CNT_W-1:0] limit;

    // Pacing applies only when every channel steals cycles.
    always_comb begin
        active = (&steal_i) && (pace_i != PACE_NONE);
        limit  = (pace_i == PACE_LONG) ? CNT_MAX : CNT_SHRT;
        open_o = !active || (cnt_q >= limit);
    end

    // Count bus clocks since the last grant, restarting on each grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_MAX;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (bus_en_i && (cnt_q < CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dmarb_select.sv
// Priority selector: walks the channels in the order the mode defines and
// returns the first one that is requesting. The rotating order starts at
// start_i. The skip order assumes at least four channels.
module dmarb_select
    import dmarb_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int IDX_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]   req_i,
    input  order_e           order_i,
    input  logic [IDX_W-1:0] start_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W:0] NCH_W = (IDX_W+1)'(NCH);

    logic [IDX_W:0]   sum;
    logic [IDX_W-1:0] cand;

    // Scan the ranking positions from highest to lowest and keep the first hit.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        sum   = '0;
        cand  = '0;
        for (int pos = 0; pos < NCH; pos++) begin
            sum = {1'b0, start_i} + (IDX_W+1)'(pos);
            if (sum >= NCH_W) begin
                sum = sum - NCH_W;
            end
            case (order_i)
                ORD_ROTATE: cand = sum[IDX_W-1:0];
                ORD_SKIP: begin
                    if (pos == 1)      cand = IDX_W'(2);
                    else if (pos == 2) cand = IDX_W'(3);
                    else if (pos == 3) cand = IDX_W'(1);
                    else               cand = IDX_W'(pos);
                end
                default:    cand = IDX_W'(pos);
            endcase
            if (!any_o && req_i[cand]) begin
                any_o = 1'b1;
                idx_o = cand;
            end
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
// Six-channel DMA request arbiter top. Holds one grant at a time until the
// done strobe, then arbitrates again on the next edge. The rotation pointer
// tracks the channel after the last grant, in every order mode.
// Assumes xfer_done_i is pulsed only while a grant is active.
module dma_req_arbiter
    import dmarb_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req_i,
    input  logic [NCH-1:0]   steal_mode_i,
    input  logic             busclk_en_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [CFG_W-1:0] cfg_rdata_o,
    input  logic             xfer_done_i,
    output logic [NCH-1:0]   grant_o,
    output logic             grant_vld_o
);
    localparam int IDX_W = $clog2(NCH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCH - 1);

    order_e           order;
    pace_e            pace;
    logic             pace_open;
    logic             any_req;
    logic [IDX_W-1:0] win_idx;
    logic [IDX_W-1:0] ptr_q;
    logic [NCH-1:0]   grant_q;
    logic             vld_q;
    logic             take;

    dmarb_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (cfg_wr_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .order_o (order),
        .pace_o  (pace)
    );

    dmarb_select #(.NCH(NCH), .IDX_W(IDX_W)) u_sel (
        .req_i   (req_i),
        .order_i (order),
        .start_i (ptr_q),
        .any_o   (any_req),
        .idx_o   (win_idx)
    );

    dmarb_pacer #(.NCH(NCH)) u_pace (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en_i  (busclk_en_i),
        .pace_i    (pace),
        .steal_i   (steal_mode_i),
        .restart_i (take),
        .open_o    (pace_open)
    );

    // A new grant is taken when idle, something is requesting, and the pacer allows it.
    assign take = !vld_q && any_req && pace_open;

    // Grant holding, release on done, and rotation pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            grant_q <= '0;
            ptr_q   <= '0;
        end else if (vld_q) begin
            if (xfer_done_i) begin
                vld_q   <= 1'b0;
                grant_q <= '0;
            end
        end else if (take) begin
            vld_q   <= 1'b1;
            grant_q <= NCH'(1) << win_idx;
            ptr_q   <= (win_idx == LAST_IDX) ? '0 : win_idx + 1'b1;
        end
    end

    assign grant_o     = grant_q;
    assign grant_vld_o = vld_q;
endmodule

// File: rtl/dmarb_checker.sv
// Property checker for the DMA request arbiter, bound to every instance.
// Keeps its own count of bus-clock enables since each grant, so it can check
// the pacing gaps.
module dmarb_checker
    import dmarb_pkg::*;
#(
    parameter int NCH = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   req_i,
    input logic [NCH-1:0]   steal_mode_i,
    input logic             busclk_en_i,
    input logic [CFG_W-1:0] cfg_rdata_o,
    input logic             xfer_done_i,
    input logic [NCH-1:0]   grant_o,
    input logic             grant_vld_o
);
    logic [6:0] gap_q;
    logic       vld_prev_q;
    logic       pace_on;

    assign pace_on = (&steal_mode_i) && cfg_rdata_o[PACE_LSB+1];

    // Independent bus-clock count since the last observed grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q      <= 7'd64;
            vld_prev_q <= 1'b0;
        end else begin
            vld_prev_q <= grant_vld_o;
            if (grant_vld_o && !vld_prev_q) begin
                gap_q <= busclk_en_i ? 7'd1 : 7'd0;
            end else if (busclk_en_i && gap_q < 7'd64) begin
                gap_q <= gap_q + 7'd1;
            end
        end
    end

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata_o & ~CFG_LIVE_MASK) == '0);

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> ($countones(grant_o) == 1));

    p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld_o |-> (grant_o == '0));

    p_grant_requested_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_vld_o) |-> ((grant_o & $past(req_i)) != '0));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld_o && !xfer_done_i) |=> (grant_vld_o && $stable(grant_o)));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld_o && xfer_done_i) |=> !grant_vld_o);

    p_gap_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_vld_o) && $past(pace_on) && !$past(cfg_rdata_o[PACE_LSB]))
        |-> ($past(gap_q) >= 7'd16));

    p_gap_long_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_vld_o) && $past(pace_on) && $past(cfg_rdata_o[PACE_LSB]))
        |-> ($past(gap_q) >= 7'd64));
endmodule

bind dma_req_arbiter dmarb_checker #(.NCH(NCH)) u_dmarb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .steal_mode_i (steal_mode_i),
    .busclk_en_i  (busclk_en_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .xfer_done_i  (xfer_done_i),
    .grant_o      (grant_o),
    .grant_vld_o  (grant_vld_o)
);

// File: tb/dma_req_arbiter_tb_top.sv
// Directed bench for the DMA request arbiter: one task per scenario.
// Inputs are driven and outputs sampled on the falling clock edge.
module dma_req_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  req_i = '0;
    logic [5:0]  steal_mode_i = '0;
    logic        busclk_en_i = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [15:0] cfg_wdata_i = '0;
    logic [15:0] cfg_rdata_o;
    logic        xfer_done_i = 1'b0;
    logic [5:0]  grant_o;
    logic        grant_vld_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dma_req_arbiter dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .steal_mode_i (steal_mode_i),
        .busclk_en_i  (busclk_en_i),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .cfg_rdata_o  (cfg_rdata_o),
        .xfer_done_i  (xfer_done_i),
        .grant_o      (grant_o),
        .grant_vld_o  (grant_vld_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_i = '0;
        steal_mode_i = '0;
        busclk_en_i = 1'b0;
        cfg_wr_i = 1'b0;
        xfer_done_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        cfg_wr_i = 1'b1;
        cfg_wdata_i = v;
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    task automatic wait_vld(input string tag);
        int n = 0;
        while (!grant_vld_o && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (!grant_vld_o) chk({tag, " grant never came"}, 0, 1);
    endtask

    task automatic pulse_done();
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
    endtask

    // Wait for a grant, compare it with the expected channel, then release it.
    task automatic expect_grant(input int idx, input string tag);
        wait_vld(tag);
        chk(tag, grant_o, 1 << idx);
        pulse_done();
    endtask

    // Called at the first falling edge with a grant: immediate done, then count cycles to the next grant.
    task automatic measure_gap(output int n);
        n = 0;
        xfer_done_i = 1'b1;
        @(negedge clk);
        n++;
        xfer_done_i = 1'b0;
        while (!grant_vld_o && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R11 reset readback", cfg_rdata_o, 0);
        chk("R11 reset grant", grant_o, 0);
        chk("R11 reset valid", grant_vld_o, 0);
        chk("R2 idle grant zero", grant_o, 0);
    endtask

    task automatic t_register();
        wr_cfg(16'hFFFF);
        chk("R1 reserved bits read zero", cfg_rdata_o, 16'h3300);
        wr_cfg(16'h1200);
        chk("R6 undefined codes kept", cfg_rdata_o, 16'h1200);
        wr_cfg(16'h2100);
        chk("R1 live fields read back", cfg_rdata_o, 16'h2100);
        wr_cfg(16'h0000);
    endtask

    task automatic one_shot(input logic [5:0] mask, input int idx, input string tag);
        req_i = mask;
        expect_grant(idx, tag);
        req_i = '0;
        @(negedge clk);
    endtask

    task automatic t_ascend();
        do_reset();
        one_shot(6'h3F, 0, "R3 all requesting");
        one_shot(6'h3E, 1, "R3 channel 0 idle");
        one_shot(6'h28, 3, "R3 channels 3 and 5");
        one_shot(6'h30, 4, "R3 channels 4 and 5");
    endtask

    task automatic t_skip();
        do_reset();
        wr_cfg(16'h0100);
        one_shot(6'h3E, 2, "R4 two above one");
        one_shot(6'h3A, 3, "R4 three above one");
        one_shot(6'h32, 1, "R4 one above four");
        one_shot(6'h21, 0, "R4 zero highest");
    endtask

    task automatic t_undefined_order();
        do_reset();
        wr_cfg(16'h0200);
        one_shot(6'h0A, 1, "R6 order 10 acts ascending");
        one_shot(6'h0C, 2, "R6 order 10 channel 2 over 3");
    endtask

    task automatic t_rotate();
        do_reset();
        wr_cfg(16'h0300);
        req_i = 6'h3F;
        expect_grant(0, "R5 first after reset");
        expect_grant(1, "R5 rotate to 1");
        expect_grant(2, "R5 rotate to 2");
        expect_grant(3, "R5 rotate to 3");
        expect_grant(4, "R5 rotate to 4");
        expect_grant(5, "R5 rotate to 5");
        expect_grant(0, "R5 wrap to 0");
        req_i = 6'h21;
        expect_grant(5, "R5 search after last");
        expect_grant(0, "R5 wrap after 5");
        req_i = '0;
        @(negedge clk);
    endtask

    task automatic t_hold();
        int bad = 0;
        do_reset();
        req_i = 6'h20;
        wait_vld("R7 hold setup");
        req_i = 6'h3F;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (grant_o != 6'h20 || !grant_vld_o) bad++;
        end
        chk("R7 grant held without done", bad, 0);
        pulse_done();
        chk("R7 released after done", grant_vld_o, 0);
        @(negedge clk);
        chk("R7 next grant one edge later", grant_o, 6'h01);
        pulse_done();
        req_i = '0;
        @(negedge clk);
    endtask

    task automatic paced_setup(input logic [15:0] cfg, input logic [5:0] steal);
        int n;
        do_reset();
        steal_mode_i = steal;
        busclk_en_i = 1'b1;
        wr_cfg(cfg);
        req_i = 6'h01;
        n = 0;
        while (!grant_vld_o && n < 3) begin
            @(negedge clk);
            n++;
        end
        chk("R11 first grant not paced", grant_vld_o, 1);
    endtask

    task automatic t_pace_short();
        int n;
        int bad = 0;
        paced_setup(16'h2000, 6'h3F);
        measure_gap(n);
        chk("R8 gap of 16 bus clocks", n, 17);
        measure_gap(n);
        chk("R8 gap repeats", n, 17);
        busclk_en_i = 1'b0;
        pulse_done();
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (grant_vld_o) bad++;
        end
        chk("R8 no grant without bus clocks", bad, 0);
        busclk_en_i = 1'b1;
        n = 0;
        while (!grant_vld_o && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk("R8 grant after 16 enables", n, 17);
    endtask

    task automatic t_pace_long();
        int n;
        paced_setup(16'h3000, 6'h3F);
        measure_gap(n);
        chk("R9 gap of 64 bus clocks", n, 65);
    endtask

    task automatic t_pace_mixed();
        int n;
        paced_setup(16'h3000, 6'h1F);
        measure_gap(n);
        chk("R10 pacing off with mixed bus modes", n, 2);
    endtask

    task automatic t_pace_undefined();
        int n;
        paced_setup(16'h1000, 6'h3F);
        measure_gap(n);
        chk("R6 pacing 01 acts as none", n, 2);
    endtask

    initial begin
        t_reset_state();
        t_register();
        t_ascend();
        t_skip();
        t_undefined_order();
        t_rotate();
        t_hold();
        t_pace_short();
        t_pace_long();
        t_pace_mixed();
        t_pace_undefined();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule